// File: doc/BRIEF.md
# Cached Vector Register File

This block gives the vector pipeline a full file of 32 architectural vector registers while storing only a few of them on chip. A tag table maps each architectural register number to one of `NUM_SLOTS` physical slots. Each slot carries a valid flag, a dirty flag and the architectural number it holds. An access whose operands are all resident finishes at once from the compact storage. An access that names a non-resident register holds `acc_ready` low. The block then frees a slot by evicting the least recently used unlocked register, writing it back only if it is dirty. After that it brings the missing register in, either as zeros or from memory.

An access names up to two source registers and one destination. The sources are read in the cycle where `acc_valid` and `acc_ready` are both high, and the destination is written at the end of that cycle. Every register has a fixed backing location at `BASE_ADDR + index * (VLEN/8)`. A register that has never been written back has no meaningful backing copy, so it is brought in as zeros without a memory read. The memory side is a valid/ready request channel carrying a write-enable, plus a response channel for read data.

Top module: `vreg_cache`

## Requirements
- R1: Software sees 32 architectural registers, indexed by 5-bit numbers. A source read returns the value last written to that register, or zero if it was never written, no matter how often it has been evicted and refilled.
- R2: When every enabled operand is resident, `acc_ready` is high in the same cycle `acc_valid` is presented, and no memory request is made.
- R3: After reset no register is resident. The first access to a register that has never been written back installs zeros and issues no memory read.
- R4: Reads and writes both refresh recency. Within one access the update order is rs1, then rs2, then rd. When a slot is needed, an invalid unlocked slot is used first; otherwise the least recently used unlocked register is the victim.
- R5: A dirty victim is written to memory (`mem_req_we`=1) at its backing address `BASE_ADDR + index*(VLEN/8)` with its contents. A clean victim is dropped with no memory write.
- R6: A memory read is issued only for a missing source operand whose register was written back earlier. A missing destination that is not also a source gets a slot with no memory read.
- R7: While a write-back or fill is pending, `acc_ready` stays low. A memory request, once raised, holds its address and direction until `mem_req_ready` accepts it.
- R8: Registers already resident for a pending access are locked against eviction. An access with three distinct non-resident registers completes with correct data (`NUM_SLOTS` >= 3).
- R9: When an access reads and writes the same register, the read returns the old value, and the next access sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Access completes this cycle |
| rs1_en | input | 1 | First source used |
| rs1_idx | input | 5 | First source register number |
| rs2_en | input | 1 | Second source used |
| rs2_idx | input | 5 | Second source register number |
| rd_en | input | 1 | Destination used |
| rd_idx | input | 5 | Destination register number |
| rd_wdata | input | VLEN | Destination write value |
| rs1_rdata | output | VLEN | First source value |
| rs2_rdata | output | VLEN | Second source value |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_req_addr | output | AW | Backing byte address |
| mem_req_wdata | output | VLEN | Write-back data |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_rdata | input | VLEN | Fill data |

## Verification
The assertions assume that the pipeline holds an access and all of its operand fields steady from the cycle `acc_valid` rises until `acc_ready` accepts it. They also assume that memory sends exactly one response for each accepted read, and only after accepting it. The lock and request-stability properties depend on both points. The bench changes access inputs only after the completing edge. Its memory model returns one response per accepted read after zero to two idle cycles, and raises `mem_req_ready` at random so that requests stall.

// File: rtl/vrc_pkg.sv
`timescale 1ns/1ps
package vrc_pkg;
  localparam int unsigned ARCH_REGS = 32;
  localparam int unsigned ARCH_W    = 5;
  localparam int unsigned NUM_OPS   = 3;

  typedef enum logic [1:0] {
    ST_LOOK      = 2'd0,
    ST_SPILL     = 2'd1,
    ST_FILL_REQ  = 2'd2,
    ST_FILL_WAIT = 2'd3
  } vrc_state_e;
endpackage

// File: rtl/vrc_tagstore.sv
`timescale 1ns/1ps
module vrc_tagstore #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned NQ        = 3,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NQ-1:0][IDX_W-1:0]      q_idx,
  output logic [NQ-1:0]                 q_hit,
  output logic [NQ-1:0][SLOT_W-1:0]     q_slot,
  input  logic                          ins_en,
  input  logic [SLOT_W-1:0]             ins_slot,
  input  logic [IDX_W-1:0]              ins_tag,
  input  logic                          inv_en,
  input  logic [SLOT_W-1:0]             inv_slot,
  input  logic                          dset_en,
  input  logic [SLOT_W-1:0]             dset_slot,
  output logic [NUM_SLOTS-1:0]          valid_o,
  output logic [NUM_SLOTS-1:0]          dirty_o,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0] tag_o
);
  logic [NUM_SLOTS-1:0]            valid_q, valid_d;
  logic [NUM_SLOTS-1:0]            dirty_q, dirty_d;
  logic [NUM_SLOTS-1:0][IDX_W-1:0] tag_q, tag_d;

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    tag_d   = tag_q;
    if (inv_en) begin
      valid_d[inv_slot] = 1'b0;
      dirty_d[inv_slot] = 1'b0;
    end
    if (dset_en) dirty_d[dset_slot] = 1'b1;
    if (ins_en) begin
      valid_d[ins_slot] = 1'b1;
      dirty_d[ins_slot] = 1'b0;
      tag_d[ins_slot]   = ins_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
      tag_q   <= tag_d;
    end
  end

  always_comb begin
    q_hit  = '0;
    q_slot = '0;
    for (int unsigned q = 0; q < NQ; q++) begin
      for (int unsigned s = 0; s < NUM_SLOTS; s++) begin
        if (valid_q[s] && (tag_q[s] == q_idx[q])) begin
          q_hit[q]  = 1'b1;
          q_slot[q] = SLOT_W'(s);
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign dirty_o = dirty_q;
  assign tag_o   = tag_q;

  logic dup_tag;
  always_comb begin
    dup_tag = 1'b0;
    for (int unsigned a = 0; a < NUM_SLOTS; a++)
      for (int unsigned b = a + 1; b < NUM_SLOTS; b++)
        if (valid_q[a] && valid_q[b] && (tag_q[a] == tag_q[b])) dup_tag = 1'b1;
  end

  // R1: one architectural register never lives in two slots
  p_unique_tag_r1: assert property (@(posedge clk) disable iff (!rst_n) !dup_tag);
  // R5: a dirty slot is always a valid slot
  p_dirty_valid_r5: assert property (@(posedge clk) disable iff (!rst_n) (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/vrc_lru.sv
`timescale 1ns/1ps
module vrc_lru #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NT        = 3,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NT-1:0]               touch_en,
  input  logic [NT-1:0][SLOT_W-1:0]   touch_slot,
  input  logic [NUM_SLOTS-1:0]        lock_mask,
  input  logic [NUM_SLOTS-1:0]        valid_i,
  output logic [SLOT_W-1:0]           victim_o
);
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] age_q, age_d;
  logic [SLOT_W-1:0]                ref_age;

  // Ages form a permutation: 0 = newest, NUM_SLOTS-1 = oldest.
  always_comb begin
    age_d   = age_q;
    ref_age = '0;
    for (int unsigned t = 0; t < NT; t++) begin
      if (touch_en[t]) begin
        ref_age = age_d[touch_slot[t]];
        for (int unsigned k = 0; k < NUM_SLOTS; k++)
          if (age_d[k] < ref_age) age_d[k] = age_d[k] + SLOT_W'(1);
        age_d[touch_slot[t]] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned k = 0; k < NUM_SLOTS; k++) age_q[k] <= SLOT_W'(k);
    end else if (|touch_en) begin
      age_q <= age_d;
    end
  end

  logic              inv_found, old_found;
  logic [SLOT_W-1:0] inv_pick, old_pick, old_age;
  always_comb begin
    inv_found = 1'b0;
    old_found = 1'b0;
    inv_pick  = '0;
    old_pick  = '0;
    old_age   = '0;
    for (int unsigned k = 0; k < NUM_SLOTS; k++) begin
      if (!lock_mask[k]) begin
        if (!valid_i[k] && !inv_found) begin
          inv_found = 1'b1;
          inv_pick  = SLOT_W'(k);
        end
        if (!old_found || (age_q[k] > old_age)) begin
          old_found = 1'b1;
          old_pick  = SLOT_W'(k);
          old_age   = age_q[k];
        end
      end
    end
    victim_o = inv_found ? inv_pick : old_pick;
  end

  logic [NUM_SLOTS-1:0] newest_vec, oldest_vec;
  always_comb begin
    for (int unsigned k = 0; k < NUM_SLOTS; k++) begin
      newest_vec[k] = (age_q[k] == '0);
      oldest_vec[k] = (age_q[k] == SLOT_W'(NUM_SLOTS - 1));
    end
  end

  // R4: recency order stays a strict ranking
  p_one_newest_r4: assert property (@(posedge clk) disable iff (!rst_n) $countones(newest_vec) == 1);
  p_one_oldest_r4: assert property (@(posedge clk) disable iff (!rst_n) $countones(oldest_vec) == 1);
endmodule

// File: rtl/vreg_cache.sv
`timescale 1ns/1ps
module vreg_cache
  import vrc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned VLEN      = 64,
  parameter int unsigned AW        = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned VBYTES   = VLEN / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              rs1_en,
  input  logic [ARCH_W-1:0] rs1_idx,
  input  logic              rs2_en,
  input  logic [ARCH_W-1:0] rs2_idx,
  input  logic              rd_en,
  input  logic [ARCH_W-1:0] rd_idx,
  input  logic [VLEN-1:0]   rd_wdata,
  output logic [VLEN-1:0]   rs1_rdata,
  output logic [VLEN-1:0]   rs2_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [VLEN-1:0]   mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [VLEN-1:0]   mem_rsp_rdata
);
  localparam int unsigned OP_RD = NUM_OPS - 1;

  function automatic logic [AW-1:0] backing_addr(input logic [ARCH_W-1:0] idx);
    return AW'(BASE_ADDR) + (AW'(idx) * AW'(VBYTES));
  endfunction

  // Operand bundle: 0 = rs1, 1 = rs2, 2 = rd
  logic [NUM_OPS-1:0]                  op_en;
  logic [NUM_OPS-1:0][ARCH_W-1:0]      op_idx;
  logic [NUM_OPS-1:0]                  q_hit, miss;
  logic [NUM_OPS-1:0][SLOT_W-1:0]      q_slot;
  assign op_en  = {rd_en, rs2_en, rs1_en};
  assign op_idx = {rd_idx, rs2_idx, rs1_idx};
  assign miss   = op_en & ~q_hit;

  vrc_state_e        state_q, state_d;
  logic [SLOT_W-1:0] vic_q, vic_d;
  logic [ARCH_W-1:0] tgt_q, tgt_d;
  logic [ARCH_REGS-1:0] spilled_q, spilled_d;
  logic [VLEN-1:0]   data_q [NUM_SLOTS];

  logic                            ins_en, inv_en, dset_en;
  logic [SLOT_W-1:0]               ins_slot, inv_slot, dset_slot;
  logic [ARCH_W-1:0]               ins_tag;
  logic [NUM_SLOTS-1:0]            slot_valid, slot_dirty, lock_mask;
  logic [NUM_SLOTS-1:0][ARCH_W-1:0] slot_tag;
  logic [NUM_OPS-1:0]              touch_en;
  logic [NUM_OPS-1:0][SLOT_W-1:0]  touch_slot;
  logic [SLOT_W-1:0]               victim;
  logic                            data_we;
  logic [SLOT_W-1:0]               data_slot;
  logic [VLEN-1:0]                 data_wval;

  vrc_tagstore #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(ARCH_W), .NQ(NUM_OPS)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .q_idx(op_idx), .q_hit(q_hit), .q_slot(q_slot),
    .ins_en(ins_en), .ins_slot(ins_slot), .ins_tag(ins_tag),
    .inv_en(inv_en), .inv_slot(inv_slot),
    .dset_en(dset_en), .dset_slot(dset_slot),
    .valid_o(slot_valid), .dirty_o(slot_dirty), .tag_o(slot_tag)
  );

  vrc_lru #(.NUM_SLOTS(NUM_SLOTS), .NT(NUM_OPS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch_en), .touch_slot(touch_slot),
    .lock_mask(lock_mask), .valid_i(slot_valid), .victim_o(victim)
  );

  // Slots holding operands of the pending access are not replaceable.
  always_comb begin
    lock_mask = '0;
    for (int unsigned i = 0; i < NUM_OPS; i++)
      if (op_en[i] && q_hit[i]) lock_mask[q_slot[i]] = 1'b1;
  end

  // First missing operand in rs1, rs2, rd order.
  logic [ARCH_W-1:0] tgt_idx;
  logic              tgt_is_src;
  always_comb begin
    tgt_idx    = op_idx[0];
    tgt_is_src = 1'b1;
    if (miss[0]) begin
      tgt_idx = op_idx[0];
    end else if (miss[1]) begin
      tgt_idx = op_idx[1];
    end else if (miss[2]) begin
      tgt_idx    = op_idx[OP_RD];
      tgt_is_src = 1'b0;
    end
  end

  assign acc_ready = (state_q == ST_LOOK) && !(|miss);
  assign rs1_rdata = data_q[q_slot[0]];
  assign rs2_rdata = data_q[q_slot[1]];

  always_comb begin
    state_d       = state_q;
    vic_d         = vic_q;
    tgt_d         = tgt_q;
    spilled_d     = spilled_q;
    ins_en        = 1'b0;
    ins_slot      = vic_q;
    ins_tag       = tgt_q;
    inv_en        = 1'b0;
    inv_slot      = vic_q;
    dset_en       = 1'b0;
    dset_slot     = q_slot[OP_RD];
    data_we       = 1'b0;
    data_slot     = q_slot[OP_RD];
    data_wval     = rd_wdata;
    touch_en      = '0;
    touch_slot    = q_slot;
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = backing_addr(tgt_q);
    mem_req_wdata = data_q[vic_q];
    unique case (state_q)
      ST_LOOK: begin
        if (acc_valid && !(|miss)) begin
          touch_en = op_en;
          if (rd_en) begin
            data_we = 1'b1;
            dset_en = 1'b1;
          end
        end else if (acc_valid) begin
          vic_d = victim;
          tgt_d = tgt_idx;
          if (slot_valid[victim] && slot_dirty[victim]) begin
            state_d = ST_SPILL;
          end else if (tgt_is_src && spilled_q[tgt_idx]) begin
            state_d = ST_FILL_REQ;
          end else begin
            ins_en        = 1'b1;
            ins_slot      = victim;
            ins_tag       = tgt_idx;
            data_we       = 1'b1;
            data_slot     = victim;
            data_wval     = '0;
            touch_en[0]   = 1'b1;
            touch_slot[0] = victim;
          end
        end
      end
      ST_SPILL: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = backing_addr(slot_tag[vic_q]);
        if (mem_req_ready) begin
          inv_en                     = 1'b1;
          spilled_d[slot_tag[vic_q]] = 1'b1;
          state_d                    = ST_LOOK;
        end
      end
      ST_FILL_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (mem_rsp_valid) begin
          ins_en        = 1'b1;
          data_we       = 1'b1;
          data_slot     = vic_q;
          data_wval     = mem_rsp_rdata;
          touch_en[0]   = 1'b1;
          touch_slot[0] = vic_q;
          state_d       = ST_LOOK;
        end
      end
      default: state_d = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_LOOK;
      vic_q     <= '0;
      tgt_q     <= '0;
      spilled_q <= '0;
    end else begin
      state_q   <= state_d;
      vic_q     <= vic_d;
      tgt_q     <= tgt_d;
      spilled_q <= spilled_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_we) data_q[data_slot] <= data_wval;
  end

  // R7: request fields stay put until accepted
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));
  // R7: pipeline is stalled during memory traffic
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> !acc_ready);
  // R8: a resident operand of a pending access stays resident
  p_lock_rs1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready && rs1_en && q_hit[0]) |=> (!acc_valid || !rs1_en || (rs1_idx != $past(rs1_idx)) || q_hit[0]));
  p_lock_rs2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready && rs2_en && q_hit[1]) |=> (!acc_valid || !rs2_en || (rs2_idx != $past(rs2_idx)) || q_hit[1]));
  // R5: write-back only from a dirty resident slot
  p_spill_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SPILL) |-> (slot_valid[vic_q] && slot_dirty[vic_q]));
  // R6: reads only for registers that have a backing copy
  p_fill_backed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL_REQ) |-> spilled_q[tgt_q]);
endmodule

// File: tb/sim_vreg_cache.sv
`timescale 1ns/1ps
module sim_vreg_cache;
  localparam int unsigned VLEN   = 64;
  localparam int unsigned AW     = 32;
  localparam logic [31:0] BASE   = 32'h0000_1000;
  localparam int unsigned VBYTES = VLEN / 8;

  logic            clk, rst_n;
  logic            acc_valid, acc_ready;
  logic            rs1_en, rs2_en, rd_en;
  logic [4:0]      rs1_idx, rs2_idx, rd_idx;
  logic [VLEN-1:0] rd_wdata, rs1_rdata, rs2_rdata;
  logic            mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0]   mem_req_addr;
  logic [VLEN-1:0] mem_req_wdata;
  logic            mem_rsp_valid;
  logic [VLEN-1:0] mem_rsp_rdata;

  vreg_cache #(.NUM_SLOTS(4), .VLEN(VLEN), .AW(AW), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready),
    .rs1_en(rs1_en), .rs1_idx(rs1_idx), .rs2_en(rs2_en), .rs2_idx(rs2_idx),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_wdata(rd_wdata),
    .rs1_rdata(rs1_rdata), .rs2_rdata(rs2_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [VLEN-1:0] refr [32];
  logic [VLEN-1:0] backing [32];
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [AW-1:0] last_wr_addr = '0;
  int wait_cycles = 0;

  task automatic chk(input logic ok, input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: random accept, response after 0..2 idle cycles
  initial begin
    logic pend;
    int   pdly;
    int   pk;
    pend = 1'b0; pdly = 0; pk = 0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    for (int i = 0; i < 32; i++) backing[i] = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pdly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = backing[pk];
          pend = 1'b0;
        end else pdly--;
      end
      mem_req_ready = ($urandom % 4) != 0;
      #1;
      if (mem_req_valid && mem_req_ready && rst_n) begin
        int k;
        k = int'((mem_req_addr - BASE) / VBYTES);
        if ((mem_req_addr < BASE) || (k > 31) || (((mem_req_addr - BASE) % VBYTES) != 0)) begin
          chk(1'b0, "R5 address range", VLEN'(mem_req_addr), VLEN'(BASE));
          k = 0;
        end
        if (mem_req_we) begin
          backing[k] = mem_req_wdata;
          wr_cnt++;
          last_wr_addr = mem_req_addr;
        end else begin
          rd_cnt++;
          pend = 1'b1;
          pk   = k;
          pdly = int'($urandom % 3);
        end
      end
    end
  end

  task automatic access(input logic e1, input logic [4:0] i1, input logic e2, input logic [4:0] i2,
                        input logic ed, input logic [4:0] id, input logic [VLEN-1:0] wd);
    @(negedge clk);
    rs1_en = e1; rs1_idx = i1; rs2_en = e2; rs2_idx = i2;
    rd_en = ed; rd_idx = id; rd_wdata = wd; acc_valid = 1'b1;
    wait_cycles = 0;
    #2;
    while (!acc_ready) begin
      @(negedge clk);
      #2;
      wait_cycles++;
    end
    if (e1) chk(rs1_rdata == refr[i1], "R1 rs1 data", rs1_rdata, refr[i1]);
    if (e2) chk(rs2_rdata == refr[i2], "R1 rs2 data", rs2_rdata, refr[i2]);
    @(posedge clk);
    if (ed) refr[id] = wd;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int wc0, rc0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) refr[i] = '0;
    acc_valid = 0; rs1_en = 0; rs2_en = 0; rd_en = 0;
    rs1_idx = 0; rs2_idx = 0; rd_idx = 0; rd_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(mem_req_valid == 1'b0, "R3 reset no request", VLEN'(mem_req_valid), '0);
    chk(acc_ready == 1'b1, "R3 reset idle ready", VLEN'(acc_ready), 1);

    // R3/R5: five zero reads, no memory traffic (clean victims dropped)
    for (int r = 10; r < 15; r++) access(1, 5'(r), 0, 0, 0, 0, '0);
    chk(rd_cnt == 0, "R3 no fill read on first touch", VLEN'(rd_cnt), 0);
    chk(wr_cnt == 0, "R5 clean victims not written", VLEN'(wr_cnt), 0);

    // R2: hit completes with no wait and no memory request
    access(1, 5'd14, 0, 0, 0, 0, '0);
    chk(wait_cycles == 0, "R2 hit without stall", VLEN'(wait_cycles), 0);
    chk(rd_cnt == 0 && wr_cnt == 0, "R2 hit without memory", VLEN'(rd_cnt + wr_cnt), 0);

    // R4/R5: LRU victim choice and write-back address
    access(0, 0, 0, 0, 1, 5'd1, 64'h1111_0000_0000_0001);
    access(0, 0, 0, 0, 1, 5'd2, 64'h2222_0000_0000_0002);
    access(0, 0, 0, 0, 1, 5'd3, 64'h3333_0000_0000_0003);
    access(0, 0, 0, 0, 1, 5'd4, 64'h4444_0000_0000_0004);
    chk(wr_cnt == 0, "R5 clean evictions silent", VLEN'(wr_cnt), 0);
    access(1, 5'd1, 0, 0, 0, 0, '0);
    access(0, 0, 0, 0, 1, 5'd5, 64'h5555_0000_0000_0005);
    chk(wr_cnt == 1, "R5 one dirty write-back", VLEN'(wr_cnt), 1);
    chk(last_wr_addr == BASE + 2 * VBYTES, "R4 LRU victim is r2", VLEN'(last_wr_addr), VLEN'(BASE + 2 * VBYTES));
    chk(backing[2] == 64'h2222_0000_0000_0002, "R5 write-back data", backing[2], 64'h2222_0000_0000_0002);

    // R6: refill of a written-back source
    rc0 = rd_cnt;
    access(1, 5'd2, 0, 0, 0, 0, '0);
    chk(rd_cnt == rc0 + 1, "R6 fill read issued", VLEN'(rd_cnt), VLEN'(rc0 + 1));
    chk(last_wr_addr == BASE + 3 * VBYTES, "R4 next victim is r3", VLEN'(last_wr_addr), VLEN'(BASE + 3 * VBYTES));
    chk(wait_cycles > 0, "R7 miss stalls pipeline", VLEN'(wait_cycles), 1);

    // R6: destination-only miss allocates without a read
    rc0 = rd_cnt;
    access(0, 0, 0, 0, 1, 5'd3, 64'h3333_0000_0000_0033);
    chk(rd_cnt == rc0, "R6 no read for dest-only", VLEN'(rd_cnt), VLEN'(rc0));
    access(1, 5'd3, 0, 0, 0, 0, '0);

    // R9: read and write of the same register
    access(1, 5'd2, 0, 0, 1, 5'd2, 64'h2222_0000_0000_0099);
    access(1, 5'd2, 0, 0, 0, 0, '0);

    // R8: three distinct non-resident operands
    access(0, 0, 0, 0, 1, 5'd20, 64'hAAAA_0000_0000_0020);
    access(0, 0, 0, 0, 1, 5'd21, 64'hBBBB_0000_0000_0021);
    for (int r = 24; r < 28; r++) access(0, 0, 0, 0, 1, 5'(r), VLEN'(r) * 64'h0101);
    wc0 = wr_cnt;
    access(1, 5'd20, 1, 5'd21, 1, 5'd22, 64'hCCCC_0000_0000_0022);
    chk(wr_cnt >= wc0 + 2, "R8 victims written back", VLEN'(wr_cnt), VLEN'(wc0 + 2));
    access(1, 5'd22, 1, 5'd20, 0, 0, '0);

    // R1: random mix with locality
    for (int n = 0; n < 400; n++) begin
      logic e1, e2, ed;
      logic [4:0] a, b, c;
      e1 = $urandom % 4 != 0;
      e2 = $urandom % 2 == 0;
      ed = $urandom % 2 == 0;
      a = ($urandom % 2 == 0) ? 5'($urandom % 6) : 5'($urandom % 32);
      b = ($urandom % 2 == 0) ? 5'($urandom % 6) : 5'($urandom % 32);
      c = ($urandom % 2 == 0) ? 5'($urandom % 6) : 5'($urandom % 32);
      access(e1, a, e2, b, ed, c, {$urandom, $urandom});
    end
    for (int r = 0; r < 32; r++) access(1, 5'(r), 0, 0, 0, 0, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule